// File: doc/BRIEF.md
# SPI Sensor Transaction Monitor

This block listens, without driving anything, to the four wires of an SPI link between a host and a register-mapped motion sensor. It brings the serial clock, chip select, host-to-sensor data and sensor-to-host data into the system clock domain. It rebuilds each transaction into a single command event, followed by one event for each register byte that goes across the link.

A transaction starts when chip select falls. The first byte the host sends is the command. The command carries a direction bit, a multi-byte flag and a six-bit start address. Each later byte is taken from the line that carries the payload: the host line for a write, the sensor line for a read. It is reported together with the register address it belongs to, and that address steps up by one after every byte. The sensor's three acceleration axes are each split over a low and a high register. When both halves arrive in order within one transaction, the monitor joins them into one 16-bit sample, so that downstream logic sees whole axis readings.

Top module: `spi_sensor_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it, hdrValid, byteValid and wordValid are all 0.
- R2: Only a high-to-low transition of csNIn starts a transaction. Clock edges seen while csNIn is high produce no events, and any other chip-select change returns the monitor to idle.
- R3: The first byte on mosiIn after chip select falls is the command, sampled MSB first on rising sckIn edges. Its first bit (bit 7) is read=1/write=0 and goes to hdrRead. Its second bit (bit 6) is the multi-byte flag and goes to hdrMulti. Bits 5..0 form the start address on hdrAddr. hdrValid pulses for exactly one cycle.
- R4: Each following byte is assembled MSB first over 8 rising sckIn edges. It comes from mosiIn when the command was a write and from misoIn when it was a read. The other data line is ignored.
- R5: The first data byte carries the start address. Each further byte of the same transaction carries the previous address plus one.
- R6: A byte whose address is above 0x39 gives no byteValid pulse, although the address still advances.
- R7: A byte at 0x32, 0x34 or 0x36 is held as a low half. When the byte at the next address follows in the same transaction, wordValid pulses with wordData = {high byte, low byte} and wordAxis = 0, 1 or 2 (X, Y, Z). A held low half is dropped when the transaction ends.
- R8: A byte at 0x33, 0x35 or 0x37 with no matching low half held is reported only through byteValid, and wordValid stays 0.
- R9: If chip select rises before all 8 bits of a byte have been sampled, that partial byte produces no event.
- R10: Each event appears at the outputs exactly 3 system clock cycles after the rising sckIn edge that completes its byte (two synchronizer stages and one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | SPI serial clock from the bus (idles high) |
| csNIn | input | 1 | SPI chip select from the bus, active low |
| mosiIn | input | 1 | Host-to-sensor data line |
| misoIn | input | 1 | Sensor-to-host data line |
| hdrValid | output | 1 | One-cycle strobe: a command byte was decoded |
| hdrRead | output | 1 | Command direction, 1 = read |
| hdrMulti | output | 1 | Command multi-byte flag |
| hdrAddr | output | 6 | Command start register address |
| byteValid | output | 1 | One-cycle strobe: a register byte was decoded |
| byteAddr | output | 6 | Register address of the byte |
| byteData | output | 8 | Byte value |
| wordValid | output | 1 | One-cycle strobe: an axis sample was completed |
| wordAxis | output | 2 | Axis of the sample, 0 = X, 1 = Y, 2 = Z |
| wordData | output | 16 | Axis sample, high byte in bits 15..8 |

## Verification
Every event is due 3 system clock cycles after the bench drives the rising serial-clock edge that completes its byte. The bench notes the cycle number of every such edge, and a collector notes the cycle of every strobe it sees on a falling clock edge. The checks compare the recorded events with a model of the requirements, and compare each command and data event's cycle against its edge plus exactly 3. The bench holds each serial-clock level for several system cycles, so the single-cycle strobes cannot merge, and a missing or extra event shows up as a wrong count.

// File: rtl/spimon_pkg.sv
package spimon_pkg;

  typedef enum logic [1:0] {
    MON_IDLE = 2'd0,
    MON_CMD  = 2'd1,
    MON_DATA = 2'd2
  } monState_t;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic start;     // chip select fell: new transaction
    logic abort;     // chip select rose: back to idle
    logic shiftEn;   // sample both data lines
    logic cmdDone;   // this shift completes the command byte
    logic dataDone;  // this shift completes a data byte
  } monStrobe_t;

endpackage

// File: rtl/spimon_sync.sv
module spimon_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= RESET_VAL;
        else       stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= RESET_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/spimon_ctrl.sv
module spimon_ctrl
  import spimon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckSync,
  input  logic       csNSync,
  output monStrobe_t strobe
);

  localparam int CNT_W = $clog2(BYTE_W);

  monState_t        state;
  logic             sckPrev;
  logic             csNPrev;
  logic [CNT_W-1:0] bitCnt;

  logic sckRise;
  logic csFall;
  logic csRise;
  logic lastBit;

  assign sckRise = sckSync & ~sckPrev & ~csNSync;
  assign csFall  = csNPrev & ~csNSync;
  assign csRise  = ~csNPrev & csNSync;
  assign lastBit = (bitCnt == CNT_W'(BYTE_W - 1));

  always_comb begin
    strobe          = '0;
    strobe.start    = csFall;
    strobe.abort    = csRise;
    strobe.shiftEn  = sckRise && (state != MON_IDLE) && !csFall;
    strobe.cmdDone  = strobe.shiftEn && (state == MON_CMD) && lastBit;
    strobe.dataDone = strobe.shiftEn && (state == MON_DATA) && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= MON_IDLE;
      sckPrev <= 1'b1;
      csNPrev <= 1'b1;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckSync;
      csNPrev <= csNSync;
      if (csFall) begin
        state  <= MON_CMD;
        bitCnt <= '0;
      end else if (csRise) begin
        state  <= MON_IDLE;
        bitCnt <= '0;
      end else if (strobe.shiftEn) begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (strobe.cmdDone) state <= MON_DATA;
      end
    end
  end

endmodule

// File: rtl/spimon_dp.sv
module spimon_dp
  import spimon_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int LAST_REG   = 'h39,
  parameter int AXIS_BASE  = 'h32,
  parameter int AXIS_COUNT = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  monStrobe_t                    strobe,
  input  logic                          mosiSync,
  input  logic                          misoSync,
  output logic                          hdrValid,
  output logic                          hdrRead,
  output logic                          hdrMulti,
  output logic [BYTE_W-3:0]             hdrAddr,
  output logic                          byteValid,
  output logic [BYTE_W-3:0]             byteAddr,
  output logic [BYTE_W-1:0]             byteData,
  output logic                          wordValid,
  output logic [$clog2(AXIS_COUNT)-1:0] wordAxis,
  output logic [2*BYTE_W-1:0]           wordData
);

  localparam int ADDR_W = BYTE_W - 2;
  localparam int AW     = ADDR_W + 1;
  localparam int AXIS_W = $clog2(AXIS_COUNT);
  typedef logic [AW-1:0] addrExt_t;

  localparam addrExt_t LAST_A = addrExt_t'(LAST_REG);
  localparam addrExt_t BASE_A = addrExt_t'(AXIS_BASE);
  localparam addrExt_t END_A  = addrExt_t'(AXIS_BASE + 2 * AXIS_COUNT);

  logic [BYTE_W-2:0] shMosi;
  logic [BYTE_W-2:0] shMiso;
  logic              isRead;
  addrExt_t          curAddr;
  logic              lowHeld;
  logic [BYTE_W-1:0] lowByte;
  logic [AXIS_W-1:0] lowAxis;

  logic [BYTE_W-1:0] fullMosi;
  logic [BYTE_W-1:0] fullMiso;
  logic [BYTE_W-1:0] dataByte;
  addrExt_t          axisOff;
  logic              inAxis;
  logic              lowSlot;
  logic              highSlot;
  logic [AXIS_W-1:0] slotAxis;
  logic              inRange;

  assign fullMosi = {shMosi, mosiSync};
  assign fullMiso = {shMiso, misoSync};
  assign dataByte = isRead ? fullMiso : fullMosi;
  assign axisOff  = curAddr - BASE_A;
  assign inAxis   = (curAddr >= BASE_A) && (curAddr < END_A);
  assign lowSlot  = inAxis && !axisOff[0];
  assign highSlot = inAxis && axisOff[0];
  assign slotAxis = axisOff[AXIS_W:1];
  assign inRange  = (curAddr <= LAST_A);

  // bit shifters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shMosi <= '0;
      shMiso <= '0;
    end else if (strobe.shiftEn) begin
      shMosi <= fullMosi[BYTE_W-2:0];
      shMiso <= fullMiso[BYTE_W-2:0];
    end
  end

  // command capture and address counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isRead  <= 1'b0;
      curAddr <= '0;
    end else if (strobe.cmdDone) begin
      isRead  <= fullMosi[BYTE_W-1];
      curAddr <= {1'b0, fullMosi[ADDR_W-1:0]};
    end else if (strobe.dataDone && (curAddr != '1)) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  // axis low-half holding
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowHeld <= 1'b0;
      lowByte <= '0;
      lowAxis <= '0;
    end else if (strobe.start || strobe.abort) begin
      lowHeld <= 1'b0;
    end else if (strobe.dataDone) begin
      if (lowSlot) begin
        lowHeld <= 1'b1;
        lowByte <= dataByte;
        lowAxis <= slotAxis;
      end else begin
        lowHeld <= 1'b0;
      end
    end
  end

  // registered event outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrValid  <= 1'b0;
      hdrRead   <= 1'b0;
      hdrMulti  <= 1'b0;
      hdrAddr   <= '0;
      byteValid <= 1'b0;
      byteAddr  <= '0;
      byteData  <= '0;
      wordValid <= 1'b0;
      wordAxis  <= '0;
      wordData  <= '0;
    end else begin
      hdrValid  <= 1'b0;
      byteValid <= 1'b0;
      wordValid <= 1'b0;
      if (strobe.cmdDone) begin
        hdrValid <= 1'b1;
        hdrRead  <= fullMosi[BYTE_W-1];
        hdrMulti <= fullMosi[BYTE_W-2];
        hdrAddr  <= fullMosi[ADDR_W-1:0];
      end
      if (strobe.dataDone && inRange) begin
        byteValid <= 1'b1;
        byteAddr  <= curAddr[ADDR_W-1:0];
        byteData  <= dataByte;
        if (highSlot && lowHeld && (lowAxis == slotAxis)) begin
          wordValid <= 1'b1;
          wordAxis  <= slotAxis;
          wordData  <= {dataByte, lowByte};
        end
      end
    end
  end

endmodule

// File: rtl/spi_sensor_monitor.sv
module spi_sensor_monitor
  import spimon_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LAST_REG    = 'h39,
  parameter int AXIS_BASE   = 'h32,
  parameter int AXIS_COUNT  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sckIn,
  input  logic                          csNIn,
  input  logic                          mosiIn,
  input  logic                          misoIn,
  output logic                          hdrValid,
  output logic                          hdrRead,
  output logic                          hdrMulti,
  output logic [BYTE_W-3:0]             hdrAddr,
  output logic                          byteValid,
  output logic [BYTE_W-3:0]             byteAddr,
  output logic [BYTE_W-1:0]             byteData,
  output logic                          wordValid,
  output logic [$clog2(AXIS_COUNT)-1:0] wordAxis,
  output logic [2*BYTE_W-1:0]           wordData
);

  logic [3:0] pinSync;
  monStrobe_t strobe;

  spimon_sync #(
    .WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b1100)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .din({sckIn, csNIn, mosiIn, misoIn}),
    .dout(pinSync)
  );

  spimon_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sckSync(pinSync[3]), .csNSync(pinSync[2]),
    .strobe(strobe)
  );

  spimon_dp #(
    .BYTE_W(BYTE_W), .LAST_REG(LAST_REG),
    .AXIS_BASE(AXIS_BASE), .AXIS_COUNT(AXIS_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mosiSync(pinSync[1]), .misoSync(pinSync[0]),
    .hdrValid(hdrValid), .hdrRead(hdrRead), .hdrMulti(hdrMulti), .hdrAddr(hdrAddr),
    .byteValid(byteValid), .byteAddr(byteAddr), .byteData(byteData),
    .wordValid(wordValid), .wordAxis(wordAxis), .wordData(wordData)
  );

endmodule

// File: rtl/spimon_checker.sv
module spimon_checker #(
  parameter int BYTE_W     = 8,
  parameter int LAST_REG   = 'h39,
  parameter int AXIS_BASE  = 'h32,
  parameter int AXIS_COUNT = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          csNIn,
  input logic                          hdrValid,
  input logic                          byteValid,
  input logic [BYTE_W-3:0]             byteAddr,
  input logic [BYTE_W-1:0]             byteData,
  input logic                          wordValid,
  input logic [$clog2(AXIS_COUNT)-1:0] wordAxis,
  input logic [2*BYTE_W-1:0]           wordData
);

  // R3: command strobe lasts one cycle
  p_hdr_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> !hdrValid);

  // R4: byte strobe lasts one cycle
  p_byte_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R5: command and data events never share a cycle
  p_hdr_byte_apart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrValid && byteValid));

  // R6: no event above the last register
  p_byte_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (int'(byteAddr) <= LAST_REG));

  // R7: a sample completes on the high-half byte of its own axis
  p_word_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (byteValid &&
                   int'(byteAddr) == AXIS_BASE + 2 * int'(wordAxis) + 1 &&
                   wordData[2*BYTE_W-1:BYTE_W] == byteData));

  // R8: axis index never outside the axis count
  p_word_axis_r8: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (int'(wordAxis) < AXIS_COUNT));

endmodule

bind spi_sensor_monitor spimon_checker #(
  .BYTE_W(BYTE_W), .LAST_REG(LAST_REG),
  .AXIS_BASE(AXIS_BASE), .AXIS_COUNT(AXIS_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .csNIn(csNIn),
  .hdrValid(hdrValid), .byteValid(byteValid),
  .byteAddr(byteAddr), .byteData(byteData),
  .wordValid(wordValid), .wordAxis(wordAxis), .wordData(wordData)
);

// File: tb/tb_spi_sensor_monitor.sv
module tb_spi_sensor_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b1;
  logic csNIn = 1'b1;
  logic mosiIn = 1'b0;
  logic misoIn = 1'b0;
  logic        hdrValid, hdrRead, hdrMulti;
  logic [5:0]  hdrAddr;
  logic        byteValid;
  logic [5:0]  byteAddr;
  logic [7:0]  byteData;
  logic        wordValid;
  logic [1:0]  wordAxis;
  logic [15:0] wordData;

  spi_sensor_monitor dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn),
    .mosiIn(mosiIn), .misoIn(misoIn),
    .hdrValid(hdrValid), .hdrRead(hdrRead), .hdrMulti(hdrMulti), .hdrAddr(hdrAddr),
    .byteValid(byteValid), .byteAddr(byteAddr), .byteData(byteData),
    .wordValid(wordValid), .wordAxis(wordAxis), .wordData(wordData)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int testsRun = 0;
  int testsFailed = 0;
  logic finished = 1'b0;

  // event collector
  int hdrN = 0, byteN = 0, wordN = 0;
  logic [7:0]  hdrLog  [64];
  int          hdrCyc  [64];
  logic [13:0] byteLog [128];
  int          byteCyc [128];
  logic [17:0] wordLog [64];

  always @(negedge clk) begin
    if (hdrValid && hdrN < 64) begin
      hdrLog[hdrN] = {hdrRead, hdrMulti, hdrAddr};
      hdrCyc[hdrN] = cyc;
      hdrN = hdrN + 1;
    end
    if (byteValid && byteN < 128) begin
      byteLog[byteN] = {byteAddr, byteData};
      byteCyc[byteN] = cyc;
      byteN = byteN + 1;
    end
    if (wordValid && wordN < 64) begin
      wordLog[wordN] = {wordAxis, wordData};
      wordN = wordN + 1;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  int hdrRise;
  int byteRise [8];

  task automatic sendBit(input logic mo, input logic mi);
    @(negedge clk);
    sckIn = 1'b0; mosiIn = mo; misoIn = mi;
    repeat (3) @(negedge clk);
    sckIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // cutBits > 0: raise chip select after that many bits of the first data byte
  task automatic runTxn(input logic [7:0] cmd, input int n, input logic [47:0] d,
                        input int cutBits);
    @(negedge clk); csNIn = 1'b0;
    repeat (3) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      sendBit(cmd[b], 1'b0);
      if (b == 0) hdrRise = cyc - 3;
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = d[47-8*i -: 8];
      for (int b = 7; b >= 0; b--) begin
        if (cutBits > 0 && (7 - b) == cutBits) break;
        if (cmd[7]) sendBit(~v[b], v[b]);
        else        sendBit(v[b], ~v[b]);
        if (b == 0) byteRise[i] = cyc - 3;
      end
      if (cutBits > 0) break;
    end
    @(negedge clk); csNIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkTxn(input logic [7:0] cmd, input int n, input logic [47:0] d,
                          input int h0, input int b0, input int w0, input string tag);
    int expB, expW, a, ax;
    logic held;
    logic [7:0] low, v;
    check(hdrN == h0 + 1, "R3", {tag, " header count"}, hdrN - h0, 1);
    check(hdrLog[h0] == cmd, "R3", {tag, " header fields"}, hdrLog[h0], cmd);
    check(hdrCyc[h0] - hdrRise == 3, "R10", {tag, " header latency"},
          hdrCyc[h0] - hdrRise, 3);
    expB = 0; expW = 0; held = 1'b0; low = '0; ax = 0;
    for (int i = 0; i < n; i++) begin
      a = int'(cmd[5:0]) + i;
      v = d[47-8*i -: 8];
      if (a <= 'h39) begin
        check(byteLog[b0+expB] == {a[5:0], v}, "R4", {tag, " byte addr/data (R5)"},
              byteLog[b0+expB], {a[5:0], v});
        check(byteCyc[b0+expB] - byteRise[i] == 3, "R10", {tag, " byte latency"},
              byteCyc[b0+expB] - byteRise[i], 3);
        expB++;
      end
      if (a == 'h32 || a == 'h34 || a == 'h36) begin
        held = 1'b1; low = v; ax = (a - 'h32) / 2;
      end else if (a == 'h33 || a == 'h35 || a == 'h37) begin
        if (held && ax == (a - 'h33) / 2) begin
          check(wordLog[w0+expW] == {ax[1:0], v, low}, "R7", {tag, " word"},
                wordLog[w0+expW], {ax[1:0], v, low});
          expW++;
        end
        held = 1'b0;
      end else begin
        held = 1'b0;
      end
    end
    check(byteN - b0 == expB, "R6", {tag, " byte count"}, byteN - b0, expB);
    check(wordN - w0 == expW, "R8", {tag, " word count"}, wordN - w0, expW);
  endtask

  // {cmd, count, six data bytes}
  localparam logic [63:0] VECS [7] = '{
    {8'h5D, 8'd2, 48'hA5_3C_00_00_00_00},  // write 0x1D, two bytes
    {8'hF2, 8'd6, 48'h11_22_33_44_55_66},  // read 0x32..0x37, three samples
    {8'h78, 8'd3, 48'h0F_80_FF_00_00_00},  // write across 0x39
    {8'hB3, 8'd1, 48'h7E_00_00_00_00_00},  // lone high half
    {8'hB6, 8'd1, 48'h99_00_00_00_00_00},  // low half, transaction ends
    {8'hB7, 8'd1, 48'h42_00_00_00_00_00},  // high half in a new transaction
    {8'h40, 8'd2, 48'h01_02_00_00_00_00}   // write from address 0
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    int h0, b0, w0;
    repeat (3) @(negedge clk);
    // R1: quiet during and right after reset
    check(!hdrValid && !byteValid && !wordValid, "R1", "strobes in reset",
          {hdrValid, byteValid, wordValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!hdrValid && !byteValid && !wordValid, "R1", "strobes after reset",
          {hdrValid, byteValid, wordValid}, 0);
    repeat (4) @(negedge clk);

    foreach (VECS[k]) begin
      h0 = hdrN; b0 = byteN; w0 = wordN;
      runTxn(VECS[k][63:56], int'(VECS[k][55:48]), VECS[k][47:0], 0);
      checkTxn(VECS[k][63:56], int'(VECS[k][55:48]), VECS[k][47:0], h0, b0, w0,
               $sformatf("vec%0d", k));
    end

    // R2: clock activity with chip select high
    h0 = hdrN; b0 = byteN; w0 = wordN;
    for (int i = 0; i < 20; i++) sendBit(i[0], i[1]);
    repeat (6) @(negedge clk);
    check(hdrN == h0 && byteN == b0 && wordN == w0, "R2", "no events with cs high",
          (hdrN - h0) + (byteN - b0) + (wordN - w0), 0);

    // R9: chip select rises mid-byte
    h0 = hdrN; b0 = byteN;
    runTxn(8'h10, 1, 48'hC3_00_00_00_00_00, 5);
    check(hdrN == h0 + 1, "R9", "header before abort", hdrN - h0, 1);
    check(byteN == b0, "R9", "partial byte dropped", byteN - b0, 0);

    // R2: monitor recovers after abort
    h0 = hdrN; b0 = byteN; w0 = wordN;
    runTxn(8'h20, 1, 48'h5A_00_00_00_00_00, 0);
    checkTxn(8'h20, 1, 48'h5A_00_00_00_00_00, h0, b0, w0, "recover");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule